// File: doc/BRIEF.md
# Power-on reset time-out sequencer

This block keeps a processor core in reset after power-on, or after a wake-up from a low-power mode, until its clock source can be trusted. It chains up to three counted delays. The first is a power-up delay on a slow internal tick. The second is an oscillator start-up delay on the external oscillator tick. The third is a PLL lock delay, also on the slow tick. The oscillator-mode code and the cause of the restart decide which of these delays run.

All three delays run from the power-on pulse alone. The external active-low reset pin only gates the final release. If the pin is held low until every delay has expired, the core comes out of reset on the clock edge that follows the pin's release. Pulling the pin low while the core runs puts the core back in reset without restarting any delay.

Top module: `reset_release_seq`

## Requirements
- R1: While `por_i` is high, and on the first clock edge after it rises from any state, the block enters its power-on state. In that state `core_rst_o` is 1 and the four status flags are 0. `core_rst_o` is 0 only in the running state.
- R2: After power-on with `pwrt_dis_i` = 0, the power-up phase (`pwrt_act_o` = 1) lasts exactly `PWRT_TICKS` cycles in which `slow_tick_i` is high. With `pwrt_dis_i` = 1 the phase is skipped.
- R3: The start-up phase (`ost_act_o` = 1) follows the power-up phase and lasts exactly `OST_CYCLES` cycles in which `osc_tick_i` is high. It runs only for mode codes 0 (low-power crystal), 1 (crystal), 2 (high-speed crystal) and 3 (high-speed crystal with PLL). Codes 4 (external clock), 5 (RC), 6 (internal oscillator) and 7 (internal oscillator with clock out) skip it.
- R4: The PLL phase (`pll_act_o` = 1) runs only for mode code 3. It follows the start-up phase and lasts exactly `PLL_TICKS` cycles in which `slow_tick_i` is high.
- R5: A one-cycle `wake_i` pulse while the core is running never starts the power-up phase. It starts the start-up phase, and the PLL phase where the mode uses it, with the same lengths as in R3 and R4. Under codes 4 to 7 it leaves `core_rst_o` at 0.
- R6: The delays run whatever the level of `ext_rst_n_i`. Once they have expired with the pin low, the block holds with `pin_hold_o` = 1 and no phase flag set. When the pin rises, `core_rst_o` falls on the next clock edge.
- R7: `ext_rst_n_i` low while the core runs sets `core_rst_o` and `pin_hold_o` on the next edge, with no phase flag. The block returns to running on the edge after the pin rises.
- R8: In RC mode (code 5) with `pwrt_dis_i` = 1 there is no delay. After `por_i` falls, `core_rst_o` stays high for one cycle only (the pin-check step) and then falls.
- R9: A `por_i` pulse in the middle of a sequence clears all counters, and the following sequence runs every phase at full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on pulse, active high, synchronous to `clk` |
| ext_rst_n_i | input | 1 | External reset pin, active low, already synchronised |
| wake_i | input | 1 | One-cycle wake-from-low-power request |
| pwrt_dis_i | input | 1 | Power-up delay disable configuration bit (1 = skip) |
| osc_mode_i | input | 3 | Oscillator mode code, see R3 |
| slow_tick_i | input | 1 | Enable pulse of the slow internal clock |
| osc_tick_i | input | 1 | Enable pulse of the external oscillator |
| core_rst_o | output | 1 | Reset to the core, active high |
| pwrt_act_o | output | 1 | Power-up phase in progress |
| ost_act_o | output | 1 | Oscillator start-up phase in progress |
| pll_act_o | output | 1 | PLL lock phase in progress |
| pin_hold_o | output | 1 | Delays done, waiting for the external pin |

## Verification
Every output comes straight from the registered state, so a change in any input shows up one clock edge later. A phase ends on the edge that follows its last qualifying tick. A released pin ends reset one edge after it is seen high. The bench drives inputs and samples outputs on the falling edge. For each phase it counts the ticks that occur while that phase's flag is set, which makes the expected totals equal to the terminal counts with no cycle offset. The reset-state, pin and wake checks are all made at the first falling edge after the edge that consumes the stimulus. The sweep covers all eight mode codes with the power-up delay both enabled and disabled, on small terminal counts.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

   typedef enum logic [2:0] {
      ST_POR  = 3'd0,
      ST_PWRT = 3'd1,
      ST_OST  = 3'd2,
      ST_PLL  = 3'd3,
      ST_HOLD = 3'd4,
      ST_RUN  = 3'd5
   } seq_state_e;

   typedef enum logic [2:0] {
      OSC_LPX   = 3'd0,
      OSC_XTAL  = 3'd1,
      OSC_HSX   = 3'd2,
      OSC_HSPLL = 3'd3,
      OSC_EXT   = 3'd4,
      OSC_RC    = 3'd5,
      OSC_INT   = 3'd6,
      OSC_INTCO = 3'd7
   } osc_mode_e;

endpackage

// File: rtl/rrs_mode_decode.sv
module rrs_mode_decode
   import rrs_pkg::*;
(
   input  logic [2:0] mode_i,
   output logic       need_ost_o,
   output logic       need_pll_o
);

   always_comb begin
      need_ost_o = 1'b0;
      need_pll_o = 1'b0;
      case (osc_mode_e'(mode_i))
         OSC_LPX, OSC_XTAL, OSC_HSX: need_ost_o = 1'b1;
         OSC_HSPLL: begin
            need_ost_o = 1'b1;
            need_pll_o = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/rrs_tick_counter.sv
module rrs_tick_counter #(
   parameter int LIMIT = 2048
) (
   input  logic clk,
   input  logic clr_i,
   input  logic run_i,
   input  logic tick_i,
   output logic done_o
);

   if (LIMIT < 1) begin : g_bad_limit
      $error("rrs_tick_counter: LIMIT must be at least 1");
   end

   if (LIMIT == 1) begin : g_single
      assign done_o = run_i & tick_i;
   end else begin : g_count
      localparam int W = $clog2(LIMIT);
      localparam logic [W-1:0] LAST = W'(LIMIT - 1);

      logic [W-1:0] cnt;

      always_ff @(posedge clk) begin
         if (clr_i || !run_i)
            cnt <= '0;
         else if (tick_i)
            cnt <= cnt + 1'b1;
      end

      assign done_o = run_i & tick_i & (cnt == LAST);

      // R2
      no_overflow_chk: assert property (@(posedge clk) disable iff (clr_i)
         run_i |-> (cnt <= LAST));
   end

endmodule

// File: rtl/reset_release_seq.sv
module reset_release_seq
   import rrs_pkg::*;
#(
   parameter int PWRT_TICKS = 2048,
   parameter int OST_CYCLES = 1024,
   parameter int PLL_TICKS  = 63
) (
   input  logic       clk,
   input  logic       por_i,
   input  logic       ext_rst_n_i,
   input  logic       wake_i,
   input  logic       pwrt_dis_i,
   input  logic [2:0] osc_mode_i,
   input  logic       slow_tick_i,
   input  logic       osc_tick_i,
   output logic       core_rst_o,
   output logic       pwrt_act_o,
   output logic       ost_act_o,
   output logic       pll_act_o,
   output logic       pin_hold_o
);

   if (PWRT_TICKS < 1 || OST_CYCLES < 1 || PLL_TICKS < 1) begin : g_bad_cfg
      $error("reset_release_seq: every terminal count must be at least 1");
   end

   seq_state_e state, nxt;
   logic need_ost, need_pll;
   logic pwrt_done, ost_done, pll_done;

   rrs_mode_decode u_dec (
      .mode_i     (osc_mode_i),
      .need_ost_o (need_ost),
      .need_pll_o (need_pll)
   );

   rrs_tick_counter #(.LIMIT(PWRT_TICKS)) u_pwrt_cnt (
      .clk    (clk),
      .clr_i  (por_i),
      .run_i  (state == ST_PWRT),
      .tick_i (slow_tick_i),
      .done_o (pwrt_done)
   );

   rrs_tick_counter #(.LIMIT(OST_CYCLES)) u_ost_cnt (
      .clk    (clk),
      .clr_i  (por_i),
      .run_i  (state == ST_OST),
      .tick_i (osc_tick_i),
      .done_o (ost_done)
   );

   rrs_tick_counter #(.LIMIT(PLL_TICKS)) u_pll_cnt (
      .clk    (clk),
      .clr_i  (por_i),
      .run_i  (state == ST_PLL),
      .tick_i (slow_tick_i),
      .done_o (pll_done)
   );

   always_comb begin
      nxt = state;
      case (state)
         ST_POR: begin
            if (!pwrt_dis_i)  nxt = ST_PWRT;
            else if (need_ost) nxt = ST_OST;
            else               nxt = ST_HOLD;
         end
         ST_PWRT: if (pwrt_done) nxt = need_ost ? ST_OST : ST_HOLD;
         ST_OST:  if (ost_done)  nxt = need_pll ? ST_PLL : ST_HOLD;
         ST_PLL:  if (pll_done)  nxt = ST_HOLD;
         ST_HOLD: begin
            if (wake_i && need_ost) nxt = ST_OST;
            else if (ext_rst_n_i)   nxt = ST_RUN;
         end
         ST_RUN: begin
            if (wake_i && need_ost) nxt = ST_OST;
            else if (!ext_rst_n_i)  nxt = ST_HOLD;
         end
         default: nxt = ST_POR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (por_i) state <= ST_POR;
      else       state <= nxt;
   end

   assign core_rst_o = (state != ST_RUN);
   assign pwrt_act_o = (state == ST_PWRT);
   assign ost_act_o  = (state == ST_OST);
   assign pll_act_o  = (state == ST_PLL);
   assign pin_hold_o = (state == ST_HOLD);

   // R2
   pwrt_skip_chk: assert property (@(posedge clk) disable iff (por_i)
      (state == ST_POR && pwrt_dis_i) |=> !pwrt_act_o);

   // R4
   pll_entry_chk: assert property (@(posedge clk) disable iff (por_i)
      $rose(pll_act_o) |-> $past(ost_act_o));

   // R5
   wake_no_pwrt_chk: assert property (@(posedge clk) disable iff (por_i)
      (state == ST_RUN && wake_i) |=> !pwrt_act_o);

   // R6
   release_pin_chk: assert property (@(posedge clk) disable iff (por_i)
      $fell(core_rst_o) |-> $past(ext_rst_n_i));

   // R7
   pin_reassert_chk: assert property (@(posedge clk) disable iff (por_i)
      (state == ST_RUN && !ext_rst_n_i && !wake_i) |=> (core_rst_o && pin_hold_o));

   // R1
   one_phase_chk: assert property (@(posedge clk) disable iff (por_i)
      $countones({pwrt_act_o, ost_act_o, pll_act_o, pin_hold_o, !core_rst_o}) <= 1);

endmodule

// File: tb/reset_release_seq_test.sv
module reset_release_seq_test;

   localparam int PW = 8;
   localparam int OS = 6;
   localparam int PL = 4;

   logic clk = 1'b0;
   logic por = 1'b1, pin_n = 1'b1, wake = 1'b0, pdis = 1'b0;
   logic [2:0] mode = 3'd0;
   logic slow_tick = 1'b0, osc_tick = 1'b0;
   logic core_rst, pwrt_act, ost_act, pll_act, pin_hold;
   int checks = 0, fails = 0;
   int tcnt = 0;

   always #5 clk = ~clk;

   always @(posedge clk) begin
      tcnt      <= tcnt + 1;
      slow_tick <= ((tcnt % 4) == 3);
      osc_tick  <= ((tcnt % 2) == 1);
   end

   reset_release_seq #(.PWRT_TICKS(PW), .OST_CYCLES(OS), .PLL_TICKS(PL)) uut (
      .clk(clk), .por_i(por), .ext_rst_n_i(pin_n), .wake_i(wake),
      .pwrt_dis_i(pdis), .osc_mode_i(mode), .slow_tick_i(slow_tick),
      .osc_tick_i(osc_tick), .core_rst_o(core_rst), .pwrt_act_o(pwrt_act),
      .ost_act_o(ost_act), .pll_act_o(pll_act), .pin_hold_o(pin_hold)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // counts qualifying ticks per phase until core_rst falls or the bound runs out
   task automatic measure(output int np, output int no, output int nl,
                          output int cyc, input int bound);
      np = 0; no = 0; nl = 0; cyc = 0;
      for (int i = 0; i < bound; i++) begin
         @(negedge clk);
         wake = 1'b0;
         if (!core_rst) return;
         cyc++;
         if (pwrt_act && slow_tick) np++;
         if (ost_act && osc_tick) no++;
         if (pll_act && slow_tick) nl++;
      end
   endtask

   task automatic power_on(input string tag);
      @(negedge clk);
      por = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(core_rst && !pwrt_act && !ost_act && !pll_act && !pin_hold,
            {tag, " R1 reset state"},
            {core_rst, pwrt_act, ost_act, pll_act, pin_hold}, 5'b10000);
      por = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int np, no, nl, cyc;
      repeat (3) @(negedge clk);

      // R2 R3 R4 R8: sweep every mode code with the power-up delay on and off
      for (int m = 0; m < 8; m++) begin
         for (int d = 0; d < 2; d++) begin
            int ep, eo, el;
            mode = 3'(m);
            pdis = d[0];
            ep = (d == 0) ? PW : 0;
            eo = (m <= 3) ? OS : 0;
            el = (m == 3) ? PL : 0;
            power_on("sweep");
            measure(np, no, nl, cyc, 2000);
            check(np == ep, "R2 power-up ticks", np, ep);
            check(no == eo, "R3 start-up ticks", no, eo);
            check(nl == el, "R4 PLL ticks", nl, el);
            if (m == 5 && d == 1)
               check(cyc == 1, "R8 no delay in RC mode", cyc, 1);
         end
      end

      // R6: pin held low through all delays, then released
      mode = 3'd3; pdis = 1'b0; pin_n = 1'b0;
      power_on("pin");
      measure(np, no, nl, cyc, 300);
      check(np == PW && no == OS && nl == PL, "R6 delays run with pin low",
            np + no + nl, PW + OS + PL);
      check(core_rst && pin_hold && !pwrt_act && !ost_act && !pll_act,
            "R6 hold after delays", pin_hold, 1);
      pin_n = 1'b1;
      @(negedge clk);
      check(!core_rst, "R6 release on next edge", core_rst, 0);

      // R7: pin pulled low while running
      pin_n = 1'b0;
      @(negedge clk);
      check(core_rst && pin_hold, "R7 re-assert core reset", core_rst, 1);
      pin_n = 1'b1;
      @(negedge clk);
      check(!core_rst && !pwrt_act && !ost_act && !pll_act, "R7 return to run",
            core_rst, 0);

      // R5: wake in high-speed crystal, PLL and RC modes
      mode = 3'd2;
      @(negedge clk);
      wake = 1'b1;
      measure(np, no, nl, cyc, 500);
      check(np == 0 && no == OS && nl == 0, "R5 wake HS start-up only",
            np * 1000 + no * 10 + nl, OS * 10);
      mode = 3'd3;
      @(negedge clk);
      wake = 1'b1;
      measure(np, no, nl, cyc, 500);
      check(np == 0 && no == OS && nl == PL, "R5 wake PLL start-up and lock",
            np * 1000 + no * 10 + nl, OS * 10 + PL);
      mode = 3'd5;
      @(negedge clk);
      wake = 1'b1;
      @(negedge clk);
      wake = 1'b0;
      check(!core_rst, "R5 wake RC no reset", core_rst, 0);

      // R9: power-on pulse in the middle of the start-up phase
      mode = 3'd3; pdis = 1'b0;
      power_on("mid");
      for (int i = 0; i < 500 && !ost_act; i++) @(negedge clk);
      check(ost_act, "R9 reached start-up phase", ost_act, 1);
      power_on("restart");
      measure(np, no, nl, cyc, 2000);
      check(np == PW && no == OS && nl == PL, "R9 full length after restart",
            np * 100 + no * 10 + nl, PW * 100 + OS * 10 + PL);

      summary();
      $finish;
   end

endmodule